// File: doc/BRIEF.md
# Host/Controller Mailbox Byte RAM

This block is a byte-wide shared memory that sits between a host processor and a management controller. The host sees each byte as one 64-bit slot in a sparse register window: the byte index comes from the address bits above bit 5. Only the lower 32-bit half of each slot is live. The management controller has its own byte port into the same storage. A bitmap records which bytes have been written since reset. A byte that has never been written reads as zero, so after reset the whole memory behaves as if it were cleared.

A handful of bytes near index 0xFF form a command mailbox. The host fills in the length (0xF9), the buffer address low and high bytes (0xFA, 0xFB) and the command code (0xFE). It then writes a command identifier to 0xFF. That write is the trigger. In the same clock edge the block checks the code, writes a status byte into 0xFC and copies the identifier into 0xFD. On the next cycle it raises a one-cycle event that carries the decoded command. The block does not carry out the commands; it only decodes them and hands them over.

The depth is set by `IDX_W`. The full 16 KiB part uses `IDX_W = 14`, and the default of 12 keeps elaboration small. The mailbox offsets are fixed and need `IDX_W` of at least 9.

Top module: `mbx_ram_ctrl`

## Requirements
- R1: A host access uses byte index `h_addr_i >> 6`, and address bits 5..3 and 1..0 have no effect. A host write with bit 2 clear stores `h_wdata_i`. A host read raises `h_rvalid_o` on the next cycle, with the stored byte in bits 7..0 and zeros in bits 31..8. The read returns the value held before any write made in the same cycle.
- R2: A host access with address bit 2 set (the upper 32-bit half) changes no byte, no bitmap bit and no event. A read of that kind still raises `h_rvalid_o` and returns zero.
- R3: Reset (`rst_n` low at a clock edge) clears the written bitmap, and every byte then reads zero until it is written again.
- R4: Any byte write from either port sets bit `idx & 31` of bitmap word `idx >> 5`. The host trigger write also sets the bits for 0xFC and 0xFD. `m_trk_o` shows the word selected by `m_trk_sel_i`.
- R5: A host write to index 0xFF with a valid code in byte 0xFE leaves 0xFC equal to 0x00 and 0xFD equal to the written identifier. A read issued in the cycle after the trigger sees these values.
- R6: The valid codes are 0x01, 0x02, 0x03 and 0xF0. Any other value of byte 0xFE at the trigger sets 0xFC to 0x81 and sets `cmd_bad_o` in the event. 0xFD still gets the identifier.
- R7: `cmd_valid_o` is high for exactly the cycle after a host trigger write, and at no other time. During that cycle the block presents the event fields: `cmd_code_o` is byte 0xFE, `cmd_id_o` is the identifier, `cmd_addr_o` is {byte 0xFB, byte 0xFA} with 0xFB as the upper byte, and `cmd_len_o` is byte 0xF9 plus 1, in the range 1 to 256.
- R8: The management port writes `m_wdata_i` to `m_idx_i` on a clock edge. `m_rdata_o` shows the byte at `m_idx_i` without a clock. If both ports write the same byte in one cycle, the host value is kept.
- R9: A management write to index 0xFF stores the byte but raises no event and leaves 0xFC and 0xFD unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_valid_i | input | 1 | Host access request |
| h_we_i | input | 1 | Host write (1) or read (0) |
| h_addr_i | input | IDX_W+6 | Host window byte address |
| h_wdata_i | input | 8 | Host write byte |
| h_rvalid_o | output | 1 | Host read data valid |
| h_rdata_o | output | 32 | Host read data, byte zero-extended |
| m_we_i | input | 1 | Management write strobe |
| m_idx_i | input | IDX_W | Management byte index |
| m_wdata_i | input | 8 | Management write byte |
| m_rdata_o | output | 8 | Management read byte (combinational) |
| m_trk_sel_i | input | IDX_W-5 | Bitmap word select |
| m_trk_o | output | 32 | Selected bitmap word |
| cmd_valid_o | output | 1 | One-cycle command event |
| cmd_code_o | output | 8 | Command code |
| cmd_id_o | output | 8 | Command identifier |
| cmd_addr_o | output | 16 | Command buffer address |
| cmd_len_o | output | 9 | Transfer length, 1 to 256 |
| cmd_bad_o | output | 1 | Code was not recognised |

## Verification
The assertions assume a few things about the inputs.

- Host inputs are steady at each clock edge, and `rst_n` is driven low from time zero.
- For the management read-back property, no host write and no trigger status update hits the same byte in the cycle it checks. The property excludes those cases explicitly.

The bench keeps to these assumptions. It changes every input on the falling edge and holds reset low for several cycles before it starts. The mailbox bytes are written through the host port in separate cycles. It collides the two ports on a byte only on purpose, and never on 0xFC or 0xFD.

// File: rtl/mbx_pkg.sv
// Shared constants for the mailbox byte RAM: the fixed mailbox byte
// indices, status codes and the recognised-command check.
// Assumes the RAM depth is at least 512 bytes so every index fits.
package mbx_pkg;
    localparam int unsigned IX_LEN  = 32'h0F9;
    localparam int unsigned IX_ALO  = 32'h0FA;
    localparam int unsigned IX_AHI  = 32'h0FB;
    localparam int unsigned IX_STAT = 32'h0FC;
    localparam int unsigned IX_ECHO = 32'h0FD;
    localparam int unsigned IX_CODE = 32'h0FE;
    localparam int unsigned IX_TRIG = 32'h0FF;

    localparam logic [7:0] ST_DONE     = 8'h00;
    localparam logic [7:0] ST_BAD_CODE = 8'h81;

    typedef enum logic [7:0] {
        OP_EEPROM = 8'h01,
        OP_BAUD   = 8'h02,
        OP_PANEL  = 8'h03,
        OP_FLASH  = 8'hF0
    } op_code_e;

    // True for the four codes the decoder accepts.
    function automatic logic code_known(input logic [7:0] c);
        return (c == OP_EEPROM) || (c == OP_BAUD) ||
               (c == OP_PANEL)  || (c == OP_FLASH);
    endfunction
endpackage

// File: rtl/mbx_host_dec.sv
// Host address decoder: turns a window address into a byte index and
// tells writes, live reads and dead (upper-half) reads apart.
// Assumes one access per cycle, qualified by valid_i.
module mbx_host_dec #(
    parameter int IDX_W = 12
) (
    input  logic             valid_i,
    input  logic             we_i,
    input  logic [IDX_W+5:0] addr_i,
    output logic             wr_o,
    output logic             rd_o,
    output logic             rd_zero_o,
    output logic [IDX_W-1:0] idx_o
);
    logic unused_lo;

    // Slot index sits above the 64-byte stride; bit 2 selects the dead half.
    always_comb begin
        idx_o     = addr_i[IDX_W+5:6];
        wr_o      = valid_i && we_i && !addr_i[2];
        rd_o      = valid_i && !we_i;
        rd_zero_o = addr_i[2];
    end

    assign unused_lo = ^{addr_i[5:3], addr_i[1:0]};
endmodule

// File: rtl/mbx_track.sv
// Written-byte bitmap: one bit per RAM byte, grouped into 32-bit words
// (word = idx>>5, bit = idx&31). Cleared by reset, set by every write.
// Assumes DEPTH is a multiple of 32.
module mbx_track #(
    parameter int IDX_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_h_i,
    input  logic [IDX_W-1:0]      idx_h_i,
    input  logic                  set_m_i,
    input  logic [IDX_W-1:0]      idx_m_i,
    input  logic                  set_cmd_i,
    input  logic [IDX_W-6:0]      sel_i,
    output logic [31:0]           word_o,
    output logic [(1<<IDX_W)-1:0] written_o
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] bits_q;

    // Record each write from either port and the mailbox update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            if (set_m_i)   bits_q[idx_m_i] <= 1'b1;
            if (set_h_i)   bits_q[idx_h_i] <= 1'b1;
            if (set_cmd_i) begin
                bits_q[mbx_pkg::IX_STAT] <= 1'b1;
                bits_q[mbx_pkg::IX_ECHO] <= 1'b1;
            end
        end
    end

    assign word_o    = bits_q[{sel_i, 5'b0} +: 32];
    assign written_o = bits_q;
endmodule

// File: rtl/mbx_byte_store.sv
// Byte array with three write sources, in rising priority: management
// port, host port, mailbox status/echo update. Unwritten bytes read zero,
// gated by the bitmap, so the array itself needs no reset.
// Assumes the status update never lands in the same cycle as a host
// write to 0xFC/0xFD (the host port carries one access per cycle).
module mbx_byte_store #(
    parameter int IDX_W = 12
) (
    input  logic                  clk,
    input  logic [(1<<IDX_W)-1:0] written_i,
    input  logic                  m_we_i,
    input  logic [IDX_W-1:0]      m_idx_i,
    input  logic [7:0]            m_wdata_i,
    input  logic                  h_we_i,
    input  logic [IDX_W-1:0]      h_idx_i,
    input  logic [7:0]            h_wdata_i,
    input  logic                  upd_i,
    input  logic [7:0]            stat_i,
    input  logic [7:0]            echo_i,
    output logic [7:0]            h_rbyte_o,
    output logic [7:0]            m_rbyte_o,
    output logic [3:0][7:0]       fld_o
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int FLD_IX [4] = '{mbx_pkg::IX_LEN, mbx_pkg::IX_ALO,
                                  mbx_pkg::IX_AHI, mbx_pkg::IX_CODE};

    logic [7:0] mem [DEPTH];

    // Apply writes; later statements override earlier ones on a clash.
    always_ff @(posedge clk) begin
        if (m_we_i) mem[m_idx_i] <= m_wdata_i;
        if (h_we_i) mem[h_idx_i] <= h_wdata_i;
        if (upd_i) begin
            mem[mbx_pkg::IX_STAT] <= stat_i;
            mem[mbx_pkg::IX_ECHO] <= echo_i;
        end
    end

    // Port reads, masked to zero for bytes not yet written.
    always_comb begin
        h_rbyte_o = written_i[h_idx_i] ? mem[h_idx_i] : 8'h00;
        m_rbyte_o = written_i[m_idx_i] ? mem[m_idx_i] : 8'h00;
    end

    // Fixed taps on the mailbox fields for the command decoder.
    for (genvar g = 0; g < 4; g++) begin : g_fld
        assign fld_o[g] = written_i[FLD_IX[g]] ? mem[FLD_IX[g]] : 8'h00;
    end
endmodule

// File: rtl/mbx_cmd_unit.sv
// Mailbox command decoder: on a trigger it chooses the status byte and
// registers a one-cycle event with code, id, buffer address and length.
// Assumes the field bytes are stable in the trigger cycle.
module mbx_cmd_unit (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_i,
    input  logic [7:0] id_i,
    input  logic [7:0] len_b_i,
    input  logic [7:0] alo_i,
    input  logic [7:0] ahi_i,
    input  logic [7:0] code_i,
    output logic [7:0] stat_o,
    output logic       ev_valid_o,
    output logic [7:0] ev_code_o,
    output logic [7:0] ev_id_o,
    output logic [15:0] ev_addr_o,
    output logic [8:0] ev_len_o,
    output logic       ev_bad_o
);
    logic known;

    // Status written back into the RAM in the trigger cycle.
    always_comb begin
        known  = mbx_pkg::code_known(code_i);
        stat_o = known ? mbx_pkg::ST_DONE : mbx_pkg::ST_BAD_CODE;
    end

    // Event register: pulses for one cycle after each trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_valid_o <= 1'b0;
            ev_code_o  <= '0;
            ev_id_o    <= '0;
            ev_addr_o  <= '0;
            ev_len_o   <= '0;
            ev_bad_o   <= 1'b0;
        end else begin
            ev_valid_o <= trig_i;
            if (trig_i) begin
                ev_code_o <= code_i;
                ev_id_o   <= id_i;
                ev_addr_o <= {ahi_i, alo_i};
                ev_len_o  <= {1'b0, len_b_i} + 9'd1;
                ev_bad_o  <= !known;
            end
        end
    end
endmodule

// File: rtl/mbx_ram_ctrl.sv
// Top of the mailbox byte RAM: host window port, management byte port,
// written bitmap and command mailbox. Host reads take one cycle.
// Assumes IDX_W >= 9 so the mailbox bytes exist.
module mbx_ram_ctrl #(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             h_valid_i,
    input  logic             h_we_i,
    input  logic [IDX_W+5:0] h_addr_i,
    input  logic [7:0]       h_wdata_i,
    output logic             h_rvalid_o,
    output logic [31:0]      h_rdata_o,
    input  logic             m_we_i,
    input  logic [IDX_W-1:0] m_idx_i,
    input  logic [7:0]       m_wdata_i,
    output logic [7:0]       m_rdata_o,
    input  logic [IDX_W-6:0] m_trk_sel_i,
    output logic [31:0]      m_trk_o,
    output logic             cmd_valid_o,
    output logic [7:0]       cmd_code_o,
    output logic [7:0]       cmd_id_o,
    output logic [15:0]      cmd_addr_o,
    output logic [8:0]       cmd_len_o,
    output logic             cmd_bad_o
);
    localparam int DEPTH = 1 << IDX_W;

    logic             h_wr, h_rd, h_rd_zero, trig;
    logic [IDX_W-1:0] h_idx;
    logic [DEPTH-1:0] written;
    logic [7:0]       h_byte, stat;
    logic [3:0][7:0]  fld;

    mbx_host_dec #(.IDX_W(IDX_W)) u_dec (
        .valid_i(h_valid_i), .we_i(h_we_i), .addr_i(h_addr_i),
        .wr_o(h_wr), .rd_o(h_rd), .rd_zero_o(h_rd_zero), .idx_o(h_idx)
    );

    // Only the host writing the id byte starts a command.
    assign trig = h_wr && (h_idx == IDX_W'(mbx_pkg::IX_TRIG));

    mbx_track #(.IDX_W(IDX_W)) u_trk (
        .clk(clk), .rst_n(rst_n),
        .set_h_i(h_wr), .idx_h_i(h_idx),
        .set_m_i(m_we_i), .idx_m_i(m_idx_i),
        .set_cmd_i(trig), .sel_i(m_trk_sel_i),
        .word_o(m_trk_o), .written_o(written)
    );

    mbx_byte_store #(.IDX_W(IDX_W)) u_mem (
        .clk(clk), .written_i(written),
        .m_we_i(m_we_i), .m_idx_i(m_idx_i), .m_wdata_i(m_wdata_i),
        .h_we_i(h_wr), .h_idx_i(h_idx), .h_wdata_i(h_wdata_i),
        .upd_i(trig), .stat_i(stat), .echo_i(h_wdata_i),
        .h_rbyte_o(h_byte), .m_rbyte_o(m_rdata_o), .fld_o(fld)
    );

    mbx_cmd_unit u_cmd (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .id_i(h_wdata_i),
        .len_b_i(fld[0]), .alo_i(fld[1]), .ahi_i(fld[2]), .code_i(fld[3]),
        .stat_o(stat), .ev_valid_o(cmd_valid_o), .ev_code_o(cmd_code_o),
        .ev_id_o(cmd_id_o), .ev_addr_o(cmd_addr_o), .ev_len_o(cmd_len_o),
        .ev_bad_o(cmd_bad_o)
    );

    // Host read return register: one-cycle latency, dead half reads zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_rvalid_o <= 1'b0;
            h_rdata_o  <= '0;
        end else begin
            h_rvalid_o <= h_rd;
            h_rdata_o  <= h_rd_zero ? 32'h0 : {24'h0, h_byte};
        end
    end
endmodule

// File: rtl/mbx_ram_ctrl_chk.sv
// Property checker for mbx_ram_ctrl, attached by bind below.
// Assumes inputs are stable at each clock edge.
module mbx_ram_ctrl_chk #(
    parameter int IDX_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             h_valid_i,
    input logic             h_we_i,
    input logic [IDX_W+5:0] h_addr_i,
    input logic             h_rvalid_o,
    input logic [31:0]      h_rdata_o,
    input logic             m_we_i,
    input logic [IDX_W-1:0] m_idx_i,
    input logic [7:0]       m_wdata_i,
    input logic [7:0]       m_rdata_o,
    input logic [31:0]      m_trk_o,
    input logic             cmd_valid_o,
    input logic [7:0]       cmd_code_o,
    input logic [8:0]       cmd_len_o,
    input logic             cmd_bad_o
);
    localparam logic [IDX_W-1:0] TRIG = IDX_W'(32'h0FF);
    localparam logic [IDX_W-1:0] STAT = IDX_W'(32'h0FC);
    localparam logic [IDX_W-1:0] ECHO = IDX_W'(32'h0FD);

    // R1
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (h_rvalid_o == $past(h_valid_i && !h_we_i)));

    // R1
    rd_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_rvalid_o |-> (h_rdata_o[31:8] == 24'h0));

    // R2
    upper_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && h_rvalid_o && $past(h_addr_i[2])) |-> (h_rdata_o == 32'h0));

    // R3
    reset_clears_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (m_trk_o == 32'h0));

    // R7
    event_needs_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> $past(h_valid_i && h_we_i && !h_addr_i[2] &&
                              h_addr_i[IDX_W+5:6] == TRIG));

    // R7
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (cmd_len_o != 9'd0 && cmd_len_o <= 9'd256));

    // R6
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_bad_o) |-> !(cmd_code_o == 8'h01 || cmd_code_o == 8'h02 ||
                                         cmd_code_o == 8'h03 || cmd_code_o == 8'hF0));

    // R8
    mgmt_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(m_we_i) && $stable(m_idx_i) &&
         m_idx_i != STAT && m_idx_i != ECHO &&
         !$past(h_valid_i && h_we_i && !h_addr_i[2] && h_addr_i[IDX_W+5:6] == m_idx_i))
        |-> (m_rdata_o == $past(m_wdata_i)));
endmodule

bind mbx_ram_ctrl mbx_ram_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .h_valid_i(h_valid_i), .h_we_i(h_we_i),
    .h_addr_i(h_addr_i), .h_rvalid_o(h_rvalid_o), .h_rdata_o(h_rdata_o),
    .m_we_i(m_we_i), .m_idx_i(m_idx_i), .m_wdata_i(m_wdata_i),
    .m_rdata_o(m_rdata_o), .m_trk_o(m_trk_o), .cmd_valid_o(cmd_valid_o),
    .cmd_code_o(cmd_code_o), .cmd_len_o(cmd_len_o), .cmd_bad_o(cmd_bad_o)
);

// File: tb/tb_mbx_ram_ctrl.sv
`timescale 1ns/1ps
module tb_mbx_ram_ctrl;
    localparam int IDX_W = 12;
    localparam int NV    = 14;
    // Row: {req[1:0] (0=R1,1=R2,2=R3), op (0 wr,1 rd), upper, idx[11:0], data, expect}
    localparam logic [31:0] VEC [NV] = '{
        {2'd0, 1'b0, 1'b0, 12'h005, 8'hA5, 8'h00},
        {2'd0, 1'b1, 1'b0, 12'h005, 8'h00, 8'hA5},
        {2'd1, 1'b0, 1'b1, 12'h006, 8'h77, 8'h00},
        {2'd1, 1'b1, 1'b0, 12'h006, 8'h00, 8'h00},
        {2'd0, 1'b0, 1'b0, 12'h006, 8'h3C, 8'h00},
        {2'd1, 1'b1, 1'b1, 12'h006, 8'h00, 8'h00},
        {2'd0, 1'b1, 1'b0, 12'h006, 8'h00, 8'h3C},
        {2'd2, 1'b1, 1'b0, 12'h123, 8'h00, 8'h00},
        {2'd0, 1'b0, 1'b0, 12'hFFF, 8'h81, 8'h00},
        {2'd0, 1'b1, 1'b0, 12'hFFF, 8'h00, 8'h81},
        {2'd0, 1'b0, 1'b0, 12'h000, 8'hFF, 8'h00},
        {2'd0, 1'b1, 1'b0, 12'h000, 8'h00, 8'hFF},
        {2'd0, 1'b0, 1'b0, 12'h005, 8'h00, 8'h00},
        {2'd0, 1'b1, 1'b0, 12'h005, 8'h00, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic h_valid_i = 1'b0, h_we_i = 1'b0;
    logic [IDX_W+5:0] h_addr_i = '0;
    logic [7:0] h_wdata_i = '0;
    logic h_rvalid_o;
    logic [31:0] h_rdata_o;
    logic m_we_i = 1'b0;
    logic [IDX_W-1:0] m_idx_i = '0;
    logic [7:0] m_wdata_i = '0;
    logic [7:0] m_rdata_o;
    logic [IDX_W-6:0] m_trk_sel_i = '0;
    logic [31:0] m_trk_o;
    logic cmd_valid_o, cmd_bad_o;
    logic [7:0] cmd_code_o, cmd_id_o;
    logic [15:0] cmd_addr_o;
    logic [8:0] cmd_len_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mbx_ram_ctrl #(.IDX_W(IDX_W)) dut (.*);

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [IDX_W+5:0] mk(input logic [IDX_W-1:0] idx, input logic up);
        return {idx, 3'b010, up, 2'b11};
    endfunction

    task automatic host_wr(input logic [IDX_W-1:0] idx, input logic up, input logic [7:0] d);
        @(negedge clk);
        h_valid_i = 1'b1; h_we_i = 1'b1; h_addr_i = mk(idx, up); h_wdata_i = d;
        @(negedge clk);
        h_valid_i = 1'b0; h_we_i = 1'b0;
    endtask

    task automatic host_rd(input logic [IDX_W-1:0] idx, input logic up, output logic [31:0] d);
        @(negedge clk);
        h_valid_i = 1'b1; h_we_i = 1'b0; h_addr_i = mk(idx, up);
        @(negedge clk);
        h_valid_i = 1'b0;
        d = h_rvalid_o ? h_rdata_o : 32'hDEAD_BEEF;
    endtask

    task automatic m_wr(input logic [IDX_W-1:0] idx, input logic [7:0] d);
        @(negedge clk);
        m_we_i = 1'b1; m_idx_i = idx; m_wdata_i = d;
        @(negedge clk);
        m_we_i = 1'b0;
    endtask

    task automatic trk(input logic [IDX_W-6:0] sel, input logic [31:0] exp, input string req);
        m_trk_sel_i = sel;
        #0.1;
        check(req, "bitmap word", m_trk_o, exp);
    endtask

    initial begin
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        // R3 reset state
        check("R3", "rvalid after reset", {31'b0, h_rvalid_o}, 32'h0);
        check("R3", "cmd_valid after reset", {31'b0, cmd_valid_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        trk(0, 32'h0, "R3");
        m_idx_i = 12'h005; #0.1;
        check("R3", "mgmt read after reset", {24'h0, m_rdata_o}, 32'h0);

        // Table walk: R1/R2/R3 host window behaviour
        for (int i = 0; i < NV; i++) begin
            string rq;
            case (VEC[i][31:30])
                2'd0:    rq = "R1";
                2'd1:    rq = "R2";
                default: rq = "R3";
            endcase
            if (VEC[i][29] == 1'b0) begin
                host_wr(VEC[i][27:16], VEC[i][28], VEC[i][15:8]);
                check(rq, "no event on plain write", {31'b0, cmd_valid_o}, 32'h0);
            end else begin
                host_rd(VEC[i][27:16], VEC[i][28], rd);
                check(rq, $sformatf("table row %0d read", i), rd, {24'h0, VEC[i][7:0]});
            end
        end

        // R4 bitmap words
        trk(0, 32'h0000_0061, "R4");
        trk(7'h7F, 32'h8000_0000, "R4");
        trk(9, 32'h0, "R4");

        // R8 management port write and read-back
        m_wr(12'h040, 8'h5A);
        m_idx_i = 12'h040; #0.1;
        check("R8", "mgmt comb read", {24'h0, m_rdata_o}, 32'h5A);
        host_rd(12'h040, 1'b0, rd);
        check("R8", "host sees mgmt byte", rd, 32'h5A);
        trk(2, 32'h1, "R4");

        // R8 same-byte collision: host wins
        @(negedge clk);
        h_valid_i = 1'b1; h_we_i = 1'b1; h_addr_i = mk(12'h041, 1'b0); h_wdata_i = 8'h11;
        m_we_i = 1'b1; m_idx_i = 12'h041; m_wdata_i = 8'h22;
        @(negedge clk);
        h_valid_i = 1'b0; h_we_i = 1'b0; m_we_i = 1'b0;
        host_rd(12'h041, 1'b0, rd);
        check("R8", "collision keeps host byte", rd, 32'h11);

        // R1 read in the same cycle as a mgmt write returns the old byte
        @(negedge clk);
        h_valid_i = 1'b1; h_we_i = 1'b0; h_addr_i = mk(12'h040, 1'b0);
        m_we_i = 1'b1; m_idx_i = 12'h040; m_wdata_i = 8'h99;
        @(negedge clk);
        h_valid_i = 1'b0; m_we_i = 1'b0;
        check("R1", "read-old on concurrent write", h_rdata_o, 32'h5A);
        #0.1;
        check("R8", "mgmt sees new byte", {24'h0, m_rdata_o}, 32'h99);

        // R5/R7 valid command
        host_wr(12'h0FC, 1'b0, 8'h55);
        host_wr(12'h0F9, 1'b0, 8'h0F);
        host_wr(12'h0FA, 1'b0, 8'h34);
        host_wr(12'h0FB, 1'b0, 8'h12);
        host_wr(12'h0FE, 1'b0, 8'h03);
        check("R7", "no event on code write", {31'b0, cmd_valid_o}, 32'h0);
        host_wr(12'h0FF, 1'b0, 8'h42);
        check("R7", "event valid", {31'b0, cmd_valid_o}, 32'h1);
        check("R7", "event code", {24'h0, cmd_code_o}, 32'h03);
        check("R7", "event id", {24'h0, cmd_id_o}, 32'h42);
        check("R7", "event addr", {16'h0, cmd_addr_o}, 32'h1234);
        check("R7", "event len", {23'h0, cmd_len_o}, 32'd16);
        check("R6", "event bad clear", {31'b0, cmd_bad_o}, 32'h0);
        @(negedge clk);
        check("R7", "event single cycle", {31'b0, cmd_valid_o}, 32'h0);
        host_rd(12'h0FC, 1'b0, rd);
        check("R5", "status ok", rd, 32'h00);
        host_rd(12'h0FD, 1'b0, rd);
        check("R5", "echo id", rd, 32'h42);

        // R7 maximum length, flash code
        host_wr(12'h0F9, 1'b0, 8'hFF);
        host_wr(12'h0FE, 1'b0, 8'hF0);
        host_wr(12'h0FF, 1'b0, 8'h09);
        check("R7", "len 256", {23'h0, cmd_len_o}, 32'd256);
        check("R6", "flash code valid", {31'b0, cmd_bad_o}, 32'h0);

        // R6 unknown code
        host_wr(12'h0FE, 1'b0, 8'h04);
        host_wr(12'h0FF, 1'b0, 8'h07);
        check("R6", "bad flag", {31'b0, cmd_bad_o}, 32'h1);
        check("R6", "bad code out", {24'h0, cmd_code_o}, 32'h04);
        host_rd(12'h0FC, 1'b0, rd);
        check("R6", "status 0x81", rd, 32'h81);
        host_rd(12'h0FD, 1'b0, rd);
        check("R6", "echo on bad", rd, 32'h07);

        // R9 mgmt write to id byte: stored, no event, status untouched
        m_wr(12'h0FF, 8'h33);
        check("R9", "no event from mgmt", {31'b0, cmd_valid_o}, 32'h0);
        m_idx_i = 12'h0FF; #0.1;
        check("R9", "mgmt id stored", {24'h0, m_rdata_o}, 32'h33);
        host_rd(12'h0FD, 1'b0, rd);
        check("R9", "echo unchanged", rd, 32'h07);
        host_rd(12'h0FC, 1'b0, rd);
        check("R9", "status unchanged", rd, 32'h81);

        // R2 upper-half trigger write does nothing
        host_wr(12'h0FF, 1'b1, 8'h01);
        check("R2", "no event on upper write", {31'b0, cmd_valid_o}, 32'h0);
        host_rd(12'h0FF, 1'b0, rd);
        check("R2", "id byte kept", rd, 32'h33);

        // R3 reset mid-run, then minimum-length bad command from zeros
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        host_rd(12'h005, 1'b0, rd);
        check("R3", "byte cleared by reset", rd, 32'h0);
        host_rd(12'h041, 1'b0, rd);
        check("R3", "collision byte cleared", rd, 32'h0);
        trk(2, 32'h0, "R3");
        host_wr(12'h0FF, 1'b0, 8'h10);
        check("R7", "len 1 from zero field", {23'h0, cmd_len_o}, 32'd1);
        check("R7", "addr zero", {16'h0, cmd_addr_o}, 32'h0);
        check("R6", "zero code is bad", {31'b0, cmd_bad_o}, 32'h1);
        trk(7, 32'h3000_0000 | 32'h8000_0000, "R4");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule